// File: doc/BRIEF.md
# Prescaled Auto-Reload Down Timer

This block is a 32-bit countdown timer driven by the core clock through an 8-bit clock divider. Software programs a divide value, a reload period and a starting count over a simple register bus. It then switches the timer on through a control register. Each time the count runs out, the block raises a single-cycle interrupt and sets a sticky status flag. If automatic reload is selected, counting restarts from the period value. Otherwise the timer parks at zero and switches itself off.

A periodic system tick is the usual use. Software writes the same value N to both the period and the count, and the interrupt then repeats every (S+1)(N+1) core clocks, where S is the divide value. A divide value of zero lets every clock through.

Top module: `prescaled_down_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The register map is: address 0 is control, address 1 is the divide value (only the low 8 bits are kept), address 2 is the period and address 3 is the count. Reads are combinational from `regAddr`.
- R3: Control bit 0 is power, bit 1 is run enable and bit 2 is auto-reload. The count changes only while both power and enable are 1. With power alone, the count holds its value.
- R4: With divide value S, the count decrements once every S+1 clocks. S = 0 decrements on every clock.
- R5: When a divider tick arrives while the count is 0, `irq` is high for exactly one clock and status (control bit 3) is set. The first interrupt appears (S+1)(C+1) clocks after the clock edge that captures the enabling write, where C is the starting count.
- R6: With auto-reload set, an expiry loads the period into the count, so later interrupts follow every (S+1)(P+1) clocks.
- R7: Without auto-reload, an expiry leaves the count at 0 and clears the enable bit, and no further interrupt follows.
- R8: Writing control with bit 3 set clears status. Writing control with bit 3 clear leaves status unchanged.
- R9: The divider's internal phase restarts from zero whenever the timer is stopped or the divide value is written, so a restarted timer takes a full S+1 clocks for its first tick.
- R10: A count write takes effect on the next clock, even while the timer runs, and counting continues from the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for both read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the selected register |
| irq | output | 1 | One-clock expiry pulse |

## Verification
A write becomes visible on the read port one clock after its capturing edge. The checks therefore read registers at the falling edge after that. Each expected interrupt is computed from the capturing edge W of the enabling write as W + (S+1)(C+1), then W + (S+1)(P+1) per reload, and pushed into a queue. A monitor samples `irq` at every falling edge and compares the clock index there with the head of that queue. An interrupt that arrives with nothing pending counts as a failure, which covers the one-shot stop. Stop writes are timed to land at a chosen edge, so the frozen count has a known value for a later read.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SCALE  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd3;

  localparam int BIT_PWR  = 0;
  localparam int BIT_EN   = 1;
  localparam int BIT_AUTO = 2;
  localparam int BIT_STAT = 3;
  localparam int CTL_W    = BIT_STAT + 1;

  // Strobes from control to the count datapath
  typedef struct packed {
    logic cntWrite;
    logic reload;
    logic decrement;
  } pdtStrobes_t;
endpackage

// File: rtl/pdt_ctrl.sv
module pdt_ctrl
  import pdt_pkg::*;
#(
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [CTL_W-1:0]   ctlData,
  input  logic [SCALE_W-1:0] scaleData,
  input  logic               cntZero,
  output pdtStrobes_t        strobes,
  output logic               pwrOn,
  output logic               enOn,
  output logic               autoOn,
  output logic               statusOn,
  output logic [SCALE_W-1:0] scaleVal,
  output logic               irq
);
  logic [SCALE_W-1:0] psCnt;
  logic ctlWr, scaleWr, cntWr, running, tick, expire;

  assign ctlWr   = wrEn && (regAddr == ADDR_CTRL);
  assign scaleWr = wrEn && (regAddr == ADDR_SCALE);
  assign cntWr   = wrEn && (regAddr == ADDR_COUNT);
  assign running = pwrOn && enOn;
  assign tick    = running && (psCnt == scaleVal);
  assign expire  = tick && cntZero && !cntWr;

  always_comb begin
    strobes.cntWrite  = cntWr;
    strobes.reload    = expire && autoOn;
    strobes.decrement = tick && !cntZero && !cntWr;
  end

  // Divider phase: restarts on stop, on divide write and after each tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           psCnt <= '0;
    else if (scaleWr || !running || tick) psCnt <= '0;
    else                                  psCnt <= psCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrOn    <= 1'b0;
      enOn     <= 1'b0;
      autoOn   <= 1'b0;
      statusOn <= 1'b0;
      scaleVal <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= expire;
      if (scaleWr) scaleVal <= scaleData;
      if (ctlWr) begin
        pwrOn  <= ctlData[BIT_PWR];
        enOn   <= ctlData[BIT_EN];
        autoOn <= ctlData[BIT_AUTO];
      end else if (expire && !autoOn) begin
        enOn <= 1'b0;
      end
      if (expire)                          statusOn <= 1'b1;
      else if (ctlWr && ctlData[BIT_STAT]) statusOn <= 1'b0;
    end
  end
endmodule

// File: rtl/pdt_datapath.sv
module pdt_datapath
  import pdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  cntData,
  input  pdtStrobes_t       strobes,
  output logic [CNT_W-1:0]  periodVal,
  output logic [CNT_W-1:0]  countVal,
  output logic              cntZero
);
  logic periodWr;
  assign periodWr = wrEn && (regAddr == ADDR_PERIOD);
  assign cntZero  = (countVal == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         periodVal <= '0;
    else if (periodWr) periodVal <= cntData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  countVal <= '0;
    else if (strobes.cntWrite)  countVal <= cntData;
    else if (strobes.reload)    countVal <= periodVal;
    else if (strobes.decrement) countVal <= countVal - 1'b1;
  end
endmodule

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer
  import pdt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int SCALE_W = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  pdtStrobes_t        strobes;
  logic               pwrOn, enOn, autoOn, statusOn, cntZero;
  logic [SCALE_W-1:0] scaleVal;
  logic [CNT_W-1:0]   periodVal, countVal;

  pdt_ctrl #(.SCALE_W(SCALE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .ctlData(wrData[CTL_W-1:0]), .scaleData(wrData[SCALE_W-1:0]),
    .cntZero(cntZero), .strobes(strobes), .pwrOn(pwrOn), .enOn(enOn),
    .autoOn(autoOn), .statusOn(statusOn), .scaleVal(scaleVal), .irq(irq)
  );

  pdt_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .cntData(wrData[CNT_W-1:0]), .strobes(strobes),
    .periodVal(periodVal), .countVal(countVal), .cntZero(cntZero)
  );

  always_comb begin
    rdData = '0;
    unique case (regAddr)
      ADDR_CTRL: begin
        rdData[BIT_PWR]  = pwrOn;
        rdData[BIT_EN]   = enOn;
        rdData[BIT_AUTO] = autoOn;
        rdData[BIT_STAT] = statusOn;
      end
      ADDR_SCALE:  rdData = DATA_W'(scaleVal);
      ADDR_PERIOD: rdData = DATA_W'(periodVal);
      default:     rdData = DATA_W'(countVal);
    endcase
  end
endmodule

// File: rtl/pdt_checker.sv
module pdt_checker
  import pdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [CNT_W-1:0]  cntData,
  input logic              irq,
  input logic              pwrOn,
  input logic              enOn,
  input logic              autoOn,
  input logic              statusOn,
  input logic [CNT_W-1:0]  countVal,
  input logic [CNT_W-1:0]  periodVal,
  input pdtStrobes_t       strobes
);
  p_irq_sets_status_r5: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> statusOn);

  p_irq_needs_run_r5: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(pwrOn && enOn));

  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!(pwrOn && enOn) && !(wrEn && regAddr == ADDR_COUNT)) |=> $stable(countVal));

  p_one_shot_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !autoOn && !$past(wrEn)) |-> !enOn);

  p_reload_value_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reload |=> countVal == $past(periodVal));

  p_step_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.decrement |=> countVal == $past(countVal) - CNT_W'(1));

  p_count_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntWrite |=> countVal == $past(cntData));
endmodule

bind prescaled_down_timer pdt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
  .cntData(wrData[CNT_W-1:0]), .irq(irq), .pwrOn(pwrOn), .enOn(enOn),
  .autoOn(autoOn), .statusOn(statusOn), .countVal(countVal),
  .periodVal(periodVal), .strobes(strobes)
);

// File: tb/prescaled_down_timer_tb_top.sv
module prescaled_down_timer_tb_top;
  import pdt_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int total = 0;
  int bad = 0;
  int expQ[$];
  bit finished = 1'b0;

  prescaled_down_timer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // 125 MHz: 8 time units per period, falling edge n sits at time 8n
  always #4 clk = ~clk;

  function automatic int cyc();
    return int'($time / 8);
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected interrupt cycles as pulses appear
  always @(negedge clk) begin
    if (rstN && irq && !finished) begin
      if (expQ.size() == 0) check("R7", "interrupt with none pending", cyc(), -1);
      else check("R5", "interrupt cycle", cyc(), expQ.pop_front());
    end
  end

  // Write captured at rising edge number 'edgeN'
  task automatic wrAt(int edgeN, logic [1:0] a, logic [31:0] d);
    while (!((($time % 8) == 0) && (cyc() == edgeN - 1))) @(negedge clk);
    #1;
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  task automatic wrNext(logic [1:0] a, logic [31:0] d, output int edgeN);
    edgeN = (($time % 8) == 0) ? cyc() + 1 : cyc() + 2;
    wrAt(edgeN, a, d);
  endtask

  task automatic rd(logic [1:0] a, longint exp, string tag, string what);
    @(negedge clk);
    #1 regAddr = a;
    #1 check(tag, what, rdData, exp);
  endtask

  task automatic waitTo(int c);
    while (cyc() < c) @(negedge clk);
  endtask

  initial begin
    int w, w2, x;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1", "irq after reset", irq, 0);
    rd(ADDR_CTRL, 0, "R1", "control after reset");
    rd(ADDR_SCALE, 0, "R1", "divide after reset");
    rd(ADDR_PERIOD, 0, "R1", "period after reset");
    rd(ADDR_COUNT, 0, "R1", "count after reset");

    // R2 map, R3 power without enable holds the count
    wrNext(ADDR_SCALE, 32'h1AB, w);
    rd(ADDR_SCALE, 32'hAB, "R2", "divide keeps low 8 bits");
    wrNext(ADDR_SCALE, 0, w);
    wrNext(ADDR_PERIOD, 5, w);
    wrNext(ADDR_COUNT, 5, w);
    wrNext(ADDR_CTRL, 1, w);
    rd(ADDR_CTRL, 1, "R2", "control readback");
    rd(ADDR_PERIOD, 5, "R2", "period readback");
    waitTo(cyc() + 10);
    rd(ADDR_COUNT, 5, "R3", "count held with power only");

    // R4/R5/R6 divide 0, count=period=5
    wrNext(ADDR_CTRL, 7, w);
    expQ.push_back(w + 6); expQ.push_back(w + 12); expQ.push_back(w + 18);
    wrAt(w + 20, ADDR_CTRL, 1);
    rd(ADDR_COUNT, 3, "R6", "count after reload and two steps");
    rd(ADDR_CTRL, 9, "R5", "status set after expiry");
    wrNext(ADDR_CTRL, 9, w);
    rd(ADDR_CTRL, 1, "R8", "status cleared by bit 3");

    // R4 divide 3, count=period=2
    wrNext(ADDR_SCALE, 3, w);
    wrNext(ADDR_PERIOD, 2, w);
    wrNext(ADDR_COUNT, 2, w);
    wrNext(ADDR_CTRL, 7, w);
    expQ.push_back(w + 12); expQ.push_back(w + 24);
    wrAt(w + 26, ADDR_CTRL, 1);
    rd(ADDR_COUNT, 2, "R4", "count with divide 3");
    wrNext(ADDR_CTRL, 9, w);

    // R9 divider phase restarts after a stop
    wrNext(ADDR_PERIOD, 5, w);
    wrNext(ADDR_COUNT, 5, w);
    wrNext(ADDR_CTRL, 7, w);
    wrAt(w + 6, ADDR_CTRL, 1);
    rd(ADDR_COUNT, 4, "R9", "count after partial run");
    wrNext(ADDR_CTRL, 7, w2);
    expQ.push_back(w2 + 20);
    wrAt(w2 + 22, ADDR_CTRL, 1);
    rd(ADDR_COUNT, 5, "R9", "count reloaded after restart");
    wrNext(ADDR_CTRL, 9, w);

    // R7/R8 one-shot with divide 1
    wrNext(ADDR_SCALE, 1, w);
    wrNext(ADDR_PERIOD, 9, w);
    wrNext(ADDR_COUNT, 4, w);
    wrNext(ADDR_CTRL, 3, w);
    expQ.push_back(w + 10);
    waitTo(w + 40);
    rd(ADDR_CTRL, 9, "R7", "enable cleared after one-shot");
    rd(ADDR_COUNT, 0, "R7", "count parked at zero");
    wrNext(ADDR_CTRL, 1, w);
    rd(ADDR_CTRL, 9, "R8", "status kept when bit 3 written 0");
    wrNext(ADDR_CTRL, 9, w);
    rd(ADDR_CTRL, 1, "R8", "status cleared");

    // R10 count write while running
    wrNext(ADDR_SCALE, 0, w);
    wrNext(ADDR_PERIOD, 100, w);
    wrNext(ADDR_COUNT, 100, w);
    wrNext(ADDR_CTRL, 7, w);
    x = w + 10;
    expQ.push_back(x + 4);
    wrAt(x, ADDR_COUNT, 3);
    wrAt(x + 6, ADDR_CTRL, 1);
    rd(ADDR_COUNT, 98, "R10", "count after running write");
    wrNext(ADDR_CTRL, 9, w);

    waitTo(cyc() + 5);
    check("R5", "pending interrupts left", expQ.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      check("watchdog", "run did not end", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule